// File: doc/BRIEF.md
# Lockdown-Aware Victim Way Selector

When a lookup misses and a linefill is needed, this block picks the way of a set that receives the new line. Software programs way masks per requester and per access type. A mask bit of 1 keeps that way out of allocation. The requester ID then picks which pair of masks applies, and the instruction/data flag picks one of the pair. A build option can turn the per-requester choice off. In that case only the instruction/data flag matters.

Two rules apply to the ways that remain. Lines that carry a per-line lock bit are never evicted. Empty ways are filled before any valid line is displaced. When the set holds no empty candidate, a pseudo-random pointer sets where the search starts, and the search wraps around the set. While the line-lockdown period is active, every line that is allocated gets its lock bit set.

Top module: `victim_way_select`

## Requirements
- R1: A request sampled on a rising edge with `req_valid`=1 produces `vic_valid`=1 for exactly one cycle after that edge, with the result on `vic_way`, `vic_found` and `vic_lock`. With no request, `vic_valid` is 0 and the result outputs hold.
- R2: With `BY_REQUESTER`=1, requester `req_id`=k uses bits [k*NUM_WAYS +: NUM_WAYS] of `instr_masks` when `req_is_instr`=1, and of `data_masks` otherwise.
- R3: With `BY_REQUESTER`=0, slice 0 of the selected mask bus is used whatever `req_id` is.
- R4: A way whose bit in the selected mask is 1 is never returned.
- R5: A way whose bit in `set_locked` is 1 is never returned.
- R6: If any candidate way (not masked, not locked) has `set_valid`=0, the lowest-numbered such way is returned.
- R7: If no candidate is empty, the first candidate at or above the pointer is returned, wrapping from way NUM_WAYS-1 to way 0.
- R8: If no candidate exists, `vic_found`=0, `vic_way`=0 and `vic_lock`=0.
- R9: `vic_lock` equals `line_lock_period` AND `vic_found`.
- R10: The pointer is the low log2(NUM_WAYS) bits of a 16-bit LFSR. The LFSR starts at 16'hACE1 and steps as {s[14:0], s[15]^s[13]^s[12]^s[10]}, only on a request that finds a way.
- R11: After a synchronous reset, `vic_valid`, `vic_way`, `vic_found` and `vic_lock` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Allocation request strobe |
| req_id | input | 3 | Requester identifier |
| req_is_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| line_lock_period | input | 1 | Line-lockdown period active |
| set_valid | input | 16 | Valid bit of each way in the set |
| set_locked | input | 16 | Per-line lock bit of each way |
| data_masks | input | 128 | Data way masks, one 16-bit slice per requester |
| instr_masks | input | 128 | Instruction way masks, one 16-bit slice per requester |
| vic_valid | output | 1 | Result strobe |
| vic_way | output | 16 | One-hot chosen way |
| vic_found | output | 1 | A way was chosen |
| vic_lock | output | 1 | Lock bit for the new tag |

## Verification
Every result is due one cycle after the edge that samples `req_valid`, because only the output register lies between the inputs and the ports. The bench drives the inputs on the falling edge and pulses the request over one rising edge. It reads the outputs on the next falling edge, so each sample sits half a period after the result registers load. The pointer for the next request changes at that same edge only when a way was found. The bench advances its own LFSR model exactly then, which keeps the expected wrap-around victims aligned with the design's.

// File: rtl/vws_pkg.sv
package vws_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/vws_mask_select.sv
module vws_mask_select #(
  parameter int NUM_WAYS     = 16,
  parameter int NUM_IDS      = 8,
  parameter bit BY_REQUESTER = 1'b1,
  localparam int ID_W        = $clog2(NUM_IDS)
) (
  input  logic [ID_W-1:0]             req_id,
  input  logic                        req_is_instr,
  input  logic [NUM_IDS*NUM_WAYS-1:0] data_masks,
  input  logic [NUM_IDS*NUM_WAYS-1:0] instr_masks,
  output logic [NUM_WAYS-1:0]         excl
);
  logic [NUM_WAYS-1:0] d_sel, i_sel;

  generate
    if (BY_REQUESTER) begin : g_by_req
      assign d_sel = data_masks[req_id*NUM_WAYS +: NUM_WAYS];
      assign i_sel = instr_masks[req_id*NUM_WAYS +: NUM_WAYS];
    end else begin : g_shared
      logic unused_bits;
      assign d_sel = data_masks[NUM_WAYS-1:0];
      assign i_sel = instr_masks[NUM_WAYS-1:0];
      assign unused_bits = ^{data_masks, instr_masks, req_id};
    end
  endgenerate

  assign excl = req_is_instr ? i_sel : d_sel;
endmodule

// File: rtl/vws_lfsr_ptr.sv
module vws_lfsr_ptr
  import vws_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst)       state <= LFSR_SEED;
    else if (step) state <= lfsr_step(state);
  end

  assign ptr = state[PTR_W-1:0];

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) state != '0)
    else $error("lfsr reached all-zero state");

  // R10
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(step) && !$past(rst) |-> $stable(state))
    else $error("lfsr moved without a step");
endmodule

// File: rtl/vws_way_picker.sv
module vws_way_picker #(
  parameter int NUM_WAYS = 16,
  localparam int PTR_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] cand,
  input  logic [NUM_WAYS-1:0] valid,
  input  logic [PTR_W-1:0]    ptr,
  output logic [NUM_WAYS-1:0] pick,
  output logic                found
);
  logic [NUM_WAYS-1:0]   empty, pick_e, rot;
  logic [2*NUM_WAYS-1:0] dbl;
  logic [PTR_W-1:0]      r_idx, abs_idx;
  logic                  e_hit, r_hit;

  always_comb begin
    empty  = cand & ~valid;
    dbl    = {cand, cand} >> ptr;
    rot    = dbl[NUM_WAYS-1:0];
    pick_e = '0;
    e_hit  = 1'b0;
    r_idx  = '0;
    r_hit  = 1'b0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!e_hit && empty[i]) begin
        pick_e[i] = 1'b1;
        e_hit     = 1'b1;
      end
      if (!r_hit && rot[i]) begin
        r_idx = PTR_W'(i);
        r_hit = 1'b1;
      end
    end
    abs_idx = r_idx + ptr;
    if (e_hit)      pick = pick_e;
    else if (r_hit) pick = NUM_WAYS'(1) << abs_idx;
    else            pick = '0;
    found = |cand;
  end
endmodule

// File: rtl/victim_way_select.sv
module victim_way_select
  import vws_pkg::*;
#(
  parameter int NUM_WAYS     = 16,
  parameter int NUM_IDS      = 8,
  parameter bit BY_REQUESTER = 1'b1,
  localparam int ID_W        = $clog2(NUM_IDS),
  localparam int PTR_W       = $clog2(NUM_WAYS),
  localparam int MASK_W      = NUM_IDS * NUM_WAYS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [ID_W-1:0]     req_id,
  input  logic                req_is_instr,
  input  logic                line_lock_period,
  input  logic [NUM_WAYS-1:0] set_valid,
  input  logic [NUM_WAYS-1:0] set_locked,
  input  logic [MASK_W-1:0]   data_masks,
  input  logic [MASK_W-1:0]   instr_masks,
  output logic                vic_valid,
  output logic [NUM_WAYS-1:0] vic_way,
  output logic                vic_found,
  output logic                vic_lock
);
  logic [NUM_WAYS-1:0] excl, cand, pick;
  logic [PTR_W-1:0]    ptr;
  logic                found;

  vws_mask_select #(
    .NUM_WAYS(NUM_WAYS), .NUM_IDS(NUM_IDS), .BY_REQUESTER(BY_REQUESTER)
  ) u_mask (
    .req_id(req_id), .req_is_instr(req_is_instr),
    .data_masks(data_masks), .instr_masks(instr_masks), .excl(excl)
  );

  assign cand = ~excl & ~set_locked;

  vws_way_picker #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .cand(cand), .valid(set_valid), .ptr(ptr), .pick(pick), .found(found)
  );

  vws_lfsr_ptr #(.PTR_W(PTR_W)) u_lfsr (
    .clk(clk), .rst(rst), .step(req_valid && found), .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_valid <= 1'b0;
      vic_way   <= '0;
      vic_found <= 1'b0;
      vic_lock  <= 1'b0;
    end else begin
      vic_valid <= req_valid;
      if (req_valid) begin
        vic_way   <= pick;
        vic_found <= found;
        vic_lock  <= line_lock_period && found;
      end
    end
  end

  // R1
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    vic_valid |-> $past(req_valid))
    else $error("result strobe without request");

  // R4
  no_masked_way_chk: assert property (@(posedge clk) disable iff (rst)
    vic_valid |-> ((vic_way & $past(excl)) == '0))
    else $error("masked way chosen");

  // R5
  no_locked_line_chk: assert property (@(posedge clk) disable iff (rst)
    vic_valid |-> ((vic_way & $past(set_locked)) == '0))
    else $error("line-locked way chosen");

  // R6
  empty_first_chk: assert property (@(posedge clk) disable iff (rst)
    vic_valid && ($past(cand & ~set_valid) != '0) |-> ((vic_way & $past(set_valid)) == '0))
    else $error("valid line evicted while empty way exists");

  // R8
  found_way_chk: assert property (@(posedge clk) disable iff (rst)
    vic_valid |-> ($onehot0(vic_way) && (vic_found == (|vic_way))))
    else $error("way vector and found flag disagree");

  // R9
  lock_found_chk: assert property (@(posedge clk) disable iff (rst)
    vic_lock |-> vic_found)
    else $error("lock bit without allocation");
endmodule

// File: tb/victim_way_select_tb.sv
module victim_way_select_tb;
  localparam int NW = 16;
  localparam int NI = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_id = '0;
  logic req_is_instr = 1'b0;
  logic line_lock_period = 1'b0;
  logic [NW-1:0] set_valid = '0, set_locked = '0;
  logic [NW-1:0] dmask [NI];
  logic [NW-1:0] imask [NI];
  logic [NI*NW-1:0] data_masks, instr_masks;
  logic vic_valid, vic_found, vic_lock;
  logic [NW-1:0] vic_way;
  logic sh_valid, sh_found, sh_lock;
  logic [NW-1:0] sh_way;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] lfsr_m = 16'hACE1;

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NI; k++) begin
      data_masks[k*NW +: NW]  = dmask[k];
      instr_masks[k*NW +: NW] = imask[k];
    end
  end

  victim_way_select u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
    .req_is_instr(req_is_instr), .line_lock_period(line_lock_period),
    .set_valid(set_valid), .set_locked(set_locked),
    .data_masks(data_masks), .instr_masks(instr_masks),
    .vic_valid(vic_valid), .vic_way(vic_way), .vic_found(vic_found), .vic_lock(vic_lock)
  );

  victim_way_select #(.BY_REQUESTER(1'b0)) u_dut_shared (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
    .req_is_instr(req_is_instr), .line_lock_period(line_lock_period),
    .set_valid(set_valid), .set_locked(set_locked),
    .data_masks(data_masks), .instr_masks(instr_masks),
    .vic_valid(sh_valid), .vic_way(sh_way), .vic_found(sh_found), .vic_lock(sh_lock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected victim from the requirements (R6, R7, R8) given candidates and pointer.
  function automatic logic [NW-1:0] model_pick(input logic [NW-1:0] c, input logic [NW-1:0] v,
                                               input logic [3:0] p);
    for (int i = 0; i < NW; i++) if (c[i] && !v[i]) return NW'(1) << i;
    for (int i = 0; i < NW; i++) begin
      int j = (p + i) % NW;
      if (c[j]) return NW'(1) << j;
    end
    return '0;
  endfunction

  // One request: drive at negedge, sample at following negedge.
  task automatic req(input logic [2:0] id, input logic instr, input logic per,
                     input logic [NW-1:0] v, input logic [NW-1:0] l);
    @(negedge clk);
    req_id = id; req_is_instr = instr; line_lock_period = per;
    set_valid = v; set_locked = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (vic_found) lfsr_m = {lfsr_m[14:0], lfsr_m[15]^lfsr_m[13]^lfsr_m[12]^lfsr_m[10]};
  endtask

  task automatic t_reset;
    chk("R11 valid", vic_valid, 0);
    chk("R11 way", vic_way, 0);
    chk("R11 found", vic_found, 0);
    chk("R11 lock", vic_lock, 0);
  endtask

  task automatic t_empty_first;
    req(3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000);
    chk("R1 strobe", vic_valid, 1);
    chk("R6 lowest empty", vic_way, 16'h0001);
    req(3'd0, 1'b0, 1'b0, 16'h00FF, 16'h0000);
    chk("R6 empty above valid", vic_way, 16'h0100);
    @(negedge clk);
    chk("R1 one cycle", vic_valid, 0);
    chk("R1 hold", vic_way, 16'h0100);
  endtask

  task automatic t_id_mask;
    dmask[5] = 16'h0F00; imask[5] = 16'h00F0; dmask[0] = 16'h0001;
    req(3'd5, 1'b0, 1'b0, 16'h00FF, 16'h0000);
    chk("R2 R4 data mask id5", vic_way, 16'h1000);
    req(3'd5, 1'b1, 1'b0, 16'h000F, 16'h0000);
    chk("R2 R4 instr mask id5", vic_way, 16'h0100);
    req(3'd5, 1'b0, 1'b0, 16'h0000, 16'h0000);
    chk("R2 per-id way", vic_way, 16'h0001);
    chk("R3 shared mask", sh_way, 16'h0002);
    dmask[5] = '0; imask[5] = '0; dmask[0] = '0;
  endtask

  task automatic t_line_lock;
    req(3'd1, 1'b0, 1'b0, 16'h0000, 16'h0003);
    chk("R5 skip locked lines", vic_way, 16'h0004);
  endtask

  task automatic t_rotate;
    logic [NW-1:0] e;
    for (int n = 0; n < 6; n++) begin
      e = model_pick(16'hFFFF, 16'hFFFF, lfsr_m[3:0]);
      req(3'd2, 1'b0, 1'b0, 16'hFFFF, 16'h0000);
      chk("R7 R10 full set from pointer", vic_way, e);
    end
    e = model_pick(16'h1008, 16'hFFFF, lfsr_m[3:0]);
    req(3'd2, 1'b0, 1'b0, 16'hFFFF, 16'hEFF7);
    chk("R7 two candidates wrap", vic_way, e);
    req(3'd2, 1'b0, 1'b0, 16'hFFFF, 16'hFFFE);
    chk("R7 only way 0", vic_way, 16'h0001);
  endtask

  task automatic t_none;
    logic [NW-1:0] e;
    dmask[2] = 16'hFFFF;
    req(3'd2, 1'b0, 1'b1, 16'h0000, 16'h0000);
    chk("R8 found", vic_found, 0);
    chk("R8 way", vic_way, 0);
    chk("R8 R9 lock", vic_lock, 0);
    dmask[2] = '0;
    e = model_pick(16'hFFFF, 16'hFFFF, lfsr_m[3:0]);
    req(3'd2, 1'b0, 1'b0, 16'hFFFF, 16'h0000);
    chk("R10 no step on miss", vic_way, e);
  endtask

  task automatic t_period;
    req(3'd3, 1'b1, 1'b1, 16'h0000, 16'h0000);
    chk("R9 lock in period", vic_lock, 1);
    req(3'd3, 1'b1, 1'b0, 16'h0000, 16'h0000);
    chk("R9 no lock outside period", vic_lock, 0);
  endtask

  initial begin
    for (int k = 0; k < NI; k++) begin dmask[k] = '0; imask[k] = '0; end
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_empty_first;
    t_id_mask;
    t_line_lock;
    t_rotate;
    t_none;
    t_period;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule